// File: doc/BRIEF.md
# Three-Level Nested Loop Walker with End-Point Flags

This block steps through a schedule of up to three nested loops, one element per advance. The innermost loop is the x dimension, then y, then z as the outermost. Each loop has a programmable extent, given as the extent minus one in a 3-bit field, so every loop runs from 1 to 8 iterations. The walk covers the product of the three extents. On every element the block presents three things: the per-dimension counters, the linear element number, and a 4-bit condition nibble. The nibble marks which loops end on that element.

The walk works like an odometer. Each advance moves x forward. When x is at its last value, it returns to zero and moves y forward. When y is also at its last value, it returns to zero and moves z forward. An advance on the final element returns every counter and the linear index to zero, so the walk repeats.

A branch unit can test the nibble to close a loop at any level. The flag for each level is formed separately. Several levels can therefore be flagged on the same element.

Top module: `nlw_walker`

## Requirements
- R1: While reset is asserted, and after reset is released, the x, y and z counters, the linear index and the non-constant flag bits all read zero.
- R2: An advance increments x. When x equals its extent field, x returns to zero and y increments. When y also equals its extent field, y returns to zero and z increments.
- R3: The linear index always equals x + (xext+1)·(y + (yext+1)·z), where xext and yext are the extent fields. Each advance that is not on the last element raises the index by exactly one.
- R4: Flag bit 1 (EQ) is set exactly when x equals its extent field.
- R5: Flag bit 3 (LE) is set exactly when x and y both equal their extent fields.
- R6: Flag bit 2 (GT) is set exactly when x, y and z all equal their extent fields.
- R7: Flag bit 0 (SO) is set only on the last element, where the linear index equals the element total minus one.
- R8: An advance on the last element returns every counter and the linear index to zero.
- R9: A cycle with neither advance nor start leaves the counters and the index unchanged.
- R10: Start clears every counter and the index on the next clock edge. Start takes priority over a concurrent advance.
- R11: An extent field of zero gives that loop one iteration, so the loop ends on every element. With the x field at zero, EQ is set on every element.
- R12: A full walk lasts exactly (xext+1)·(yext+1)·(zext+1) elements. For example, fields 4, 6 and 2 give 105 elements, and SO is seen only once, at index 104.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronised internally |
| start | input | 1 | Restart the walk at element zero |
| adv | input | 1 | Step to the next element |
| xext | input | 3 | Innermost loop extent minus one |
| yext | input | 3 | Middle loop extent minus one |
| zext | input | 3 | Outermost loop extent minus one |
| idx | output | 9 | Linear element number |
| xcnt | output | 3 | Innermost loop counter |
| ycnt | output | 3 | Middle loop counter |
| zcnt | output | 3 | Outermost loop counter |
| flags | output | 4 | Condition nibble: bit3 LE, bit2 GT, bit1 EQ, bit0 SO |

## Verification
A corrupted counter or a carry that fails to ripple shows up at once as a mismatch between the linear index and the value rebuilt from the three counters. It also shows a flag raised on the wrong element. A slip in the index register stays visible until the next start or wrap, because the index never re-synchronises with the counters by itself. Every element of several full walks is compared within one cycle of the advance that produced it. The walks cover single-iteration loops and the largest configuration, so a missing or extra element shows up at the wrap point.

// File: rtl/nlw_pkg.sv
package nlw_pkg;
  localparam int DIM_W = 3;
  localparam int NDIM  = 3;
  localparam int IDX_W = DIM_W * NDIM;
  localparam int FLG_W = 4;

  // condition nibble layout
  localparam int FB_LE = 3;
  localparam int FB_GT = 2;
  localparam int FB_EQ = 1;
  localparam int FB_SO = 0;
endpackage

// File: rtl/nlw_digit.sv
module nlw_digit #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step_in,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         at_end,
  output logic         step_out
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    at_end   = (cnt == lim);
    step_out = step_in & at_end;
    cnt_en   = clr | step_in;
    if (clr || at_end) cnt_d = '0;
    else               cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/nlw_index.sv
module nlw_index #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         last,
  output logic [W-1:0] idx
);
  logic [W-1:0] idx_d;
  logic         idx_en;

  always_comb begin
    idx_en = clr | step;
    if (clr || last) idx_d = '0;
    else             idx_d = idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (idx_en) idx <= idx_d;
  end
endmodule

// File: rtl/nlw_flags.sv
module nlw_flags
  import nlw_pkg::*;
#(
  parameter int N = NDIM
) (
  input  logic [N-1:0]     at_end,
  output logic [FLG_W-1:0] flags
);
  logic [N-1:0] lvl;

  // lvl[k]: loops 0..k all finish on this element
  for (genvar k = 0; k < N; k++) begin : g_lvl
    assign lvl[k] = &at_end[k:0];
  end

  always_comb begin
    flags        = '0;
    flags[FB_EQ] = lvl[0];
    flags[FB_LE] = (N > 1) ? lvl[(N > 1) ? 1 : 0] : 1'b0;
    flags[FB_GT] = (N > 2) ? lvl[(N > 2) ? 2 : 0] : 1'b0;
    flags[FB_SO] = lvl[N-1];
  end
endmodule

// File: rtl/nlw_walker.sv
module nlw_walker
  import nlw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             adv,
  input  logic [DIM_W-1:0] xext,
  input  logic [DIM_W-1:0] yext,
  input  logic [DIM_W-1:0] zext,
  output logic [IDX_W-1:0] idx,
  output logic [DIM_W-1:0] xcnt,
  output logic [DIM_W-1:0] ycnt,
  output logic [DIM_W-1:0] zcnt,
  output logic [FLG_W-1:0] flags
);
  logic [1:0]       rsync;
  logic             core_rst_n;
  logic [DIM_W-1:0] lim  [NDIM];
  logic [DIM_W-1:0] cnt  [NDIM];
  logic [NDIM-1:0]  at_end;
  logic [NDIM:0]    carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign core_rst_n = rsync[1];

  assign lim[0]   = xext;
  assign lim[1]   = yext;
  assign lim[2]   = zext;
  assign carry[0] = adv & ~start;

  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    nlw_digit #(.W(DIM_W)) i_digit (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .clr      (start),
      .step_in  (carry[d]),
      .lim      (lim[d]),
      .cnt      (cnt[d]),
      .at_end   (at_end[d]),
      .step_out (carry[d+1])
    );
  end

  nlw_index #(.W(IDX_W)) i_index (
    .clk   (clk),
    .rst_n (core_rst_n),
    .clr   (start),
    .step  (carry[0]),
    .last  (carry[NDIM]),
    .idx   (idx)
  );

  nlw_flags #(.N(NDIM)) i_flags (
    .at_end (at_end),
    .flags  (flags)
  );

  assign xcnt = cnt[0];
  assign ycnt = cnt[1];
  assign zcnt = cnt[2];
endmodule

// File: rtl/nlw_walker_chk.sv
module nlw_walker_chk
  import nlw_pkg::*;
(
  input logic             clk,
  input logic             core_rst_n,
  input logic             start,
  input logic             adv,
  input logic [DIM_W-1:0] xext,
  input logic [DIM_W-1:0] yext,
  input logic [DIM_W-1:0] zext,
  input logic [IDX_W-1:0] idx,
  input logic [DIM_W-1:0] xcnt,
  input logic [DIM_W-1:0] ycnt,
  input logic [DIM_W-1:0] zcnt,
  input logic [FLG_W-1:0] flags
);
  int lin_v;
  int tot_v;
  always_comb begin
    lin_v = int'(xcnt) + (int'(xext) + 1) * (int'(ycnt) + (int'(yext) + 1) * int'(zcnt));
    tot_v = (int'(xext) + 1) * (int'(yext) + 1) * (int'(zext) + 1);
  end

  p_index_map_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    int'(idx) == lin_v);

  p_index_inc_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (adv && !start && !flags[FB_SO]) |=> (idx == $past(idx) + 1'b1));

  p_eq_flag_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    flags[FB_EQ] == (xcnt == xext));

  p_so_last_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    flags[FB_SO] |-> (int'(idx) == tot_v - 1));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (adv && !start && flags[FB_SO]) |=> (idx == '0 && xcnt == '0 && ycnt == '0 && zcnt == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!adv && !start) |=> ($stable(idx) && $stable(xcnt) && $stable(ycnt) && $stable(zcnt)));

  p_start_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    start |=> (idx == '0 && xcnt == '0 && ycnt == '0 && zcnt == '0));
endmodule

bind nlw_walker nlw_walker_chk i_nlw_walker_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .start      (start),
  .adv        (adv),
  .xext       (xext),
  .yext       (yext),
  .zext       (zext),
  .idx        (idx),
  .xcnt       (xcnt),
  .ycnt       (ycnt),
  .zcnt       (zcnt),
  .flags      (flags)
);

// File: tb/test_nlw_walker.sv
module test_nlw_walker;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, adv;
  logic [2:0] xext, yext, zext;
  logic [8:0] idx;
  logic [2:0] xcnt, ycnt, zcnt;
  logic [3:0] flags;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  nlw_walker i_nlw_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
    .xext(xext), .yext(yext), .zext(zext),
    .idx(idx), .xcnt(xcnt), .ycnt(ycnt), .zcnt(zcnt), .flags(flags)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic s);
    @(negedge clk);
    adv   = a;
    start = s;
    @(posedge clk);
    #2;
    adv   = 1'b0;
    start = 1'b0;
  endtask

  // compare the ports against element e of the current configuration
  task automatic expect_elem(input int e);
    int nx, ny, nz, tot, ex, ey, ez;
    bit xe, ye, ze;
    nx = int'(xext) + 1; ny = int'(yext) + 1; nz = int'(zext) + 1;
    tot = nx * ny * nz;
    ex = e % nx; ey = (e / nx) % ny; ez = e / (nx * ny);
    xe = (ex == nx - 1); ye = (ey == ny - 1); ze = (ez == nz - 1);
    chk("R2 x counter", int'(xcnt), ex);
    chk("R2 y counter", int'(ycnt), ey);
    chk("R2 z counter", int'(zcnt), ez);
    chk("R3 linear index", int'(idx), e);
    chk("R4 EQ bit1", int'(flags[1]), int'(xe));
    chk("R5 LE bit3", int'(flags[3]), int'(xe && ye));
    chk("R6 GT bit2", int'(flags[2]), int'(xe && ye && ze));
    chk("R7 SO bit0", int'(flags[0]), int'(e == tot - 1));
  endtask

  task automatic walk(input logic [2:0] xl, input logic [2:0] yl, input logic [2:0] zl);
    int tot, so_seen, so_at;
    @(negedge clk);
    xext = xl; yext = yl; zext = zl;
    tot = (int'(xl) + 1) * (int'(yl) + 1) * (int'(zl) + 1);
    cyc(1'b0, 1'b1);
    expect_elem(0);
    so_seen = 0; so_at = -1;
    if (flags[0]) begin so_seen++; so_at = 0; end
    for (int n = 1; n <= tot; n++) begin
      cyc(1'b1, 1'b0);
      expect_elem(n % tot);
      if (n % tot == 0) begin
        chk("R8 wrap index", int'(idx), 0);
        chk("R8 wrap z", int'(zcnt), 0);
      end else if (flags[0]) begin
        so_seen++; so_at = int'(idx);
      end
      if (n % 7 == 3) begin
        cyc(1'b0, 1'b0);
        chk("R9 hold index", int'(idx), n % tot);
        expect_elem(n % tot);
      end
    end
    if (tot == 1) so_seen = 1;
    if (tot == 1) so_at = 0;
    chk("R12 single SO per walk", so_seen, 1);
    chk("R12 SO position", so_at, tot - 1);
    if (xl == 3'd0) chk("R11 EQ on every element", int'(flags[1]), 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; adv = 1'b0;
    xext = 3'd2; yext = 3'd2; zext = 3'd2;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset index", int'(idx), 0);
    chk("R1 reset x", int'(xcnt), 0);
    chk("R1 reset y", int'(ycnt), 0);
    chk("R1 reset z", int'(zcnt), 0);
    chk("R1 reset flags", int'(flags), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk("R1 after release", int'(idx), 0);

    walk(3'd4, 3'd6, 3'd2);   // 105 elements, R12
    walk(3'd0, 3'd0, 3'd0);   // single element, R11
    walk(3'd0, 3'd2, 3'd1);   // x ends every element, R11
    walk(3'd2, 3'd0, 3'd3);   // y ends with x
    walk(3'd7, 3'd7, 3'd7);   // largest, 512 elements
    walk(3'd1, 3'd2, 3'd0);

    // R10: start beats a concurrent advance
    repeat (5) cyc(1'b1, 1'b0);
    chk("R10 pre-start index", int'(idx), 5);
    cyc(1'b1, 1'b1);
    chk("R10 start idx", int'(idx), 0);
    chk("R10 start x", int'(xcnt), 0);
    chk("R10 start y", int'(ycnt), 0);
    cyc(1'b1, 1'b0);
    chk("R10 resume", int'(idx), 1);
    cyc(1'b0, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule